// File: doc/BRIEF.md
# Keyboard Controller Power-Down Sequencer

This block decides when the clocks of an embedded keyboard-controller core run. It has two depths of sleep. A halt strobe from the instruction decoder parks the core in a light sleep. In light sleep only the CPU-core clock enable drops, and the timer and interrupt logic keep their clock. A stop strobe parks it in a deep sleep. In deep sleep the oscillator enable drops as well, so nothing in the controller has a clock.

The sequencer runs from an always-on clock. A host write to the data input register wakes it, and so does a core reset request. In deep sleep a host write is caught by a sticky capture stage, since the sleeping core cannot see it. Waking from deep sleep passes through a settling phase. That phase lasts at least a programmable number of cycles and also until the oscillator reports that it is stable.

On the way back the block raises exactly one one-cycle resume control, chosen by the wake cause:
- enter the interrupt routine, for a host write with the input-buffer-full interrupt enabled;
- continue at the next instruction, for a host write with that interrupt disabled;
- restart at program address zero, for a reset. Reset always wins over a host write.

States:
- RUN: the core runs.
- SOFT: light sleep.
- HARD: deep sleep.
- SETTLE: the oscillator is starting up.
- RESUME: the first core cycle back, which carries the resume control.

Transitions:
- RUN to SOFT on halt.
- RUN to HARD on stop.
- RUN to RESUME on reset.
- SOFT to RESUME on host write or reset.
- HARD to SETTLE on a captured host write or on reset.
- SETTLE to RESUME when the count is zero and the oscillator is stable.
- RESUME to RUN always.

Top module: `kbc_pwr_seq`

## Requirements
- R1: After rst_n is released the block is in RUN: core_clk_en, osc_en and tmr_clk_en are 1, and resume_irq, resume_next and resume_zero are 0.
- R2: halt_stb in RUN (without stop_stb or core_reset) gives SOFT from the next cycle: core_clk_en 0, osc_en 1, tmr_clk_en 1.
- R3: stop_stb in RUN (without core_reset) gives HARD from the next cycle: core_clk_en, osc_en and tmr_clk_en all 0. stop_stb wins over a simultaneous halt_stb.
- R4: host_wr in SOFT (without core_reset) gives RESUME in the next cycle. RESUME lasts one cycle with core_clk_en 1 and resume_irq 1 when ibf_ie is 1, or resume_next 1 when ibf_ie is 0. Then RUN follows.
- R5: core_reset in RUN or SOFT gives RESUME in the next cycle with resume_zero 1. It wins over halt_stb, stop_stb and host_wr in that cycle.
- R6: host_wr in HARD is captured into a pending flag. The cycle after the capture edge the block leaves HARD for SETTLE: osc_en 1, core_clk_en 0, tmr_clk_en 0. ibf_ie is sampled at that exit.
- R7: SETTLE lasts settle_len+1 cycles while osc_ok is 1. It is extended for as long as osc_ok is 0 after the count has run out. Then RESUME follows with the recorded cause.
- R8: core_reset in HARD, or at any time in SETTLE, makes the following RESUME carry resume_zero. This holds even when a host write also caused the wake.
- R9: The three resume controls are mutually exclusive. One is 1 only in the RESUME cycle, and core_clk_en is 1 then.
- R10: halt_stb and stop_stb have no effect outside RUN. host_wr has no effect in RUN, SETTLE and RESUME. The enable outputs and resume controls stay as if the strobe were absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| halt_stb | input | 1 | Halt instruction executed (enter light sleep) |
| stop_stb | input | 1 | Stop instruction executed (enter deep sleep) |
| core_reset | input | 1 | Core reset request (wake cause, restart at zero) |
| host_wr | input | 1 | Host write strobe to the data input register |
| ibf_ie | input | 1 | Input-buffer-full interrupt enable |
| osc_ok | input | 1 | Oscillator reports stable output |
| settle_len | input | CNT_W | Minimum settle cycles after deep-sleep wake (minus one) |
| core_clk_en | output | 1 | CPU-core clock enable |
| osc_en | output | 1 | Oscillator driver enable |
| tmr_clk_en | output | 1 | Timer/counter and interrupt clock enable |
| resume_irq | output | 1 | Resume by calling the interrupt routine |
| resume_next | output | 1 | Resume at the next instruction |
| resume_zero | output | 1 | Restart at program address zero |

## Verification
The main function is tried with several kinds of wake:
- host writes in light and in deep sleep, under both interrupt-enable settings, which tells the interrupt path from the continue path;
- reset alone and reset together with a host write, which shows that reset takes priority;
- settle lengths of zero, three and five with the oscillator-stable input held low for a while, which separates the count limit from the stability gate.

Halt, stop and write strobes are also given in states where they must be ignored. Halt and stop are given together to expose the priority between them.

// File: rtl/kbc_pwr_pkg.sv
package kbc_pwr_pkg;

    typedef enum logic [2:0] {
        PD_RUN,
        PD_SOFT,
        PD_HARD,
        PD_SETTLE,
        PD_RESUME
    } pd_state_e;

    typedef enum logic [1:0] {
        WK_NEXT,
        WK_IRQ,
        WK_ZERO
    } wake_cause_e;

    function automatic wake_cause_e write_cause(input logic irq_enabled);
        return irq_enabled ? WK_IRQ : WK_NEXT;
    endfunction

endpackage

// File: rtl/pd_wake_capture.sv
module pd_wake_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic host_wr,
    output logic pend
);
    logic pend_q;

    // Sticky while armed; cleared once the deep-sleep state is left.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (arm)
            pend_q <= pend_q | host_wr;
        else
            pend_q <= 1'b0;
    end

    assign pend = pend_q;
endmodule

// File: rtl/pd_settle_timer.sv
module pd_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [CNT_W-1:0] len,
    output logic             done
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= CNT_ZERO;
        else if (load)
            cnt_q <= len;
        else if (run && cnt_q != CNT_ZERO)
            cnt_q <= cnt_q - CNT_ONE;
    end

    assign done = (cnt_q == CNT_ZERO);
endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
    import kbc_pwr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt_stb,
    input  logic stop_stb,
    input  logic core_reset,
    input  logic host_wr,
    input  logic ibf_ie,
    input  logic osc_ok,
    input  logic wake_pend,
    input  logic settle_done,
    output logic arm_capture,
    output logic timer_load,
    output logic timer_run,
    output logic core_clk_en,
    output logic osc_en,
    output logic tmr_clk_en,
    output logic resume_irq,
    output logic resume_next,
    output logic resume_zero
);
    pd_state_e   state_q, state_d;
    wake_cause_e cause_q, cause_d;

    // Next-state and cause selection.
    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        unique case (state_q)
            PD_RUN: begin
                if (core_reset) begin
                    state_d = PD_RESUME;
                    cause_d = WK_ZERO;
                end else if (stop_stb) begin
                    state_d = PD_HARD;
                end else if (halt_stb) begin
                    state_d = PD_SOFT;
                end
            end
            PD_SOFT: begin
                if (core_reset) begin
                    state_d = PD_RESUME;
                    cause_d = WK_ZERO;
                end else if (host_wr) begin
                    state_d = PD_RESUME;
                    cause_d = write_cause(ibf_ie);
                end
            end
            PD_HARD: begin
                if (core_reset) begin
                    state_d = PD_SETTLE;
                    cause_d = WK_ZERO;
                end else if (wake_pend) begin
                    state_d = PD_SETTLE;
                    cause_d = write_cause(ibf_ie);
                end
            end
            PD_SETTLE: begin
                if (core_reset)
                    cause_d = WK_ZERO;
                if (settle_done && osc_ok)
                    state_d = PD_RESUME;
            end
            PD_RESUME: begin
                state_d = PD_RUN;
            end
            default: begin
                state_d = PD_RUN;
                cause_d = WK_NEXT;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PD_RUN;
            cause_q <= WK_NEXT;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
        end
    end

    // Moore outputs.
    always_comb begin
        core_clk_en = 1'b0;
        osc_en      = 1'b1;
        tmr_clk_en  = 1'b0;
        resume_irq  = 1'b0;
        resume_next = 1'b0;
        resume_zero = 1'b0;
        arm_capture = 1'b0;
        timer_run   = 1'b0;
        unique case (state_q)
            PD_RUN: begin
                core_clk_en = 1'b1;
                tmr_clk_en  = 1'b1;
            end
            PD_SOFT: begin
                tmr_clk_en  = 1'b1;
            end
            PD_HARD: begin
                osc_en      = 1'b0;
                arm_capture = 1'b1;
            end
            PD_SETTLE: begin
                timer_run   = 1'b1;
            end
            PD_RESUME: begin
                core_clk_en = 1'b1;
                tmr_clk_en  = 1'b1;
                resume_irq  = (cause_q == WK_IRQ);
                resume_next = (cause_q == WK_NEXT);
                resume_zero = (cause_q == WK_ZERO);
            end
            default: begin
                core_clk_en = 1'b0;
            end
        endcase
    end

    assign timer_load = (state_q == PD_HARD) && (state_d == PD_SETTLE);
endmodule

// File: rtl/kbc_pwr_seq.sv
module kbc_pwr_seq #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_stb,
    input  logic             stop_stb,
    input  logic             core_reset,
    input  logic             host_wr,
    input  logic             ibf_ie,
    input  logic             osc_ok,
    input  logic [CNT_W-1:0] settle_len,
    output logic             core_clk_en,
    output logic             osc_en,
    output logic             tmr_clk_en,
    output logic             resume_irq,
    output logic             resume_next,
    output logic             resume_zero
);
    logic arm_capture;
    logic wake_pend;
    logic timer_load;
    logic timer_run;
    logic settle_done;

    pd_wake_capture u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm_capture),
        .host_wr (host_wr),
        .pend    (wake_pend)
    );

    pd_settle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (timer_load),
        .run   (timer_run),
        .len   (settle_len),
        .done  (settle_done)
    );

    pd_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt_stb    (halt_stb),
        .stop_stb    (stop_stb),
        .core_reset  (core_reset),
        .host_wr     (host_wr),
        .ibf_ie      (ibf_ie),
        .osc_ok      (osc_ok),
        .wake_pend   (wake_pend),
        .settle_done (settle_done),
        .arm_capture (arm_capture),
        .timer_load  (timer_load),
        .timer_run   (timer_run),
        .core_clk_en (core_clk_en),
        .osc_en      (osc_en),
        .tmr_clk_en  (tmr_clk_en),
        .resume_irq  (resume_irq),
        .resume_next (resume_next),
        .resume_zero (resume_zero)
    );
endmodule

// File: rtl/kbc_pwr_seq_chk.sv
module kbc_pwr_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic halt_stb,
    input logic stop_stb,
    input logic core_reset,
    input logic host_wr,
    input logic core_clk_en,
    input logic osc_en,
    input logic tmr_clk_en,
    input logic resume_irq,
    input logic resume_next,
    input logic resume_zero
);
    logic any_resume;
    logic in_run;
    logic in_soft;
    logic in_settle;

    assign any_resume = resume_irq | resume_next | resume_zero;
    assign in_run     = core_clk_en && !any_resume;
    assign in_soft    = tmr_clk_en && !core_clk_en;
    assign in_settle  = osc_en && !tmr_clk_en;

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resume_irq, resume_next, resume_zero}));

    a_r9_core_on: assert property (@(posedge clk) disable iff (!rst_n)
        any_resume |-> core_clk_en);

    a_r2_soft_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && halt_stb && !stop_stb && !core_reset)
        |=> (!core_clk_en && osc_en && tmr_clk_en));

    a_r3_hard_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && stop_stb && !core_reset)
        |=> (!core_clk_en && !osc_en && !tmr_clk_en));

    a_r3_osc_off_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (!core_clk_en && !tmr_clk_en));

    a_r5_reset_run: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && core_reset) |=> resume_zero);

    a_r4_soft_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (in_soft && host_wr && !core_reset) |=> (resume_irq || resume_next));

    a_r8_settle_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (in_settle && core_reset) |=> (!resume_irq && !resume_next));
endmodule

bind kbc_pwr_seq kbc_pwr_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt_stb    (halt_stb),
    .stop_stb    (stop_stb),
    .core_reset  (core_reset),
    .host_wr     (host_wr),
    .core_clk_en (core_clk_en),
    .osc_en      (osc_en),
    .tmr_clk_en  (tmr_clk_en),
    .resume_irq  (resume_irq),
    .resume_next (resume_next),
    .resume_zero (resume_zero)
);

// File: tb/tb_kbc_pwr_seq.sv
`timescale 1ns/1ps
module tb_kbc_pwr_seq;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_stb = 0, stop_stb = 0, core_reset = 0, host_wr = 0;
    logic ibf_ie = 0, osc_ok = 1;
    logic [CNT_W-1:0] settle_len = 8'd3;
    logic core_clk_en, osc_en, tmr_clk_en, resume_irq, resume_next, resume_zero;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R1";

    // model state: 0 RUN 1 SOFT 2 HARD 3 SETTLE 4 RESUME; cause 0 next 1 irq 2 zero
    int m_st = 0;
    int m_cause = 0;
    int m_cnt = 0;
    bit m_pend = 0;

    always #5 clk = ~clk;

    kbc_pwr_seq #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .halt_stb(halt_stb), .stop_stb(stop_stb),
        .core_reset(core_reset), .host_wr(host_wr), .ibf_ie(ibf_ie),
        .osc_ok(osc_ok), .settle_len(settle_len), .core_clk_en(core_clk_en),
        .osc_en(osc_en), .tmr_clk_en(tmr_clk_en), .resume_irq(resume_irq),
        .resume_next(resume_next), .resume_zero(resume_zero)
    );

    task automatic model_step();
        int nst;
        bit npend;
        if (!rst_n) begin
            m_st = 0; m_cause = 0; m_cnt = 0; m_pend = 0;
            return;
        end
        nst = m_st;
        npend = (m_st == 2) ? (m_pend | host_wr) : 1'b0;
        case (m_st)
            0: if (core_reset) begin nst = 4; m_cause = 2; end
               else if (stop_stb) nst = 2;
               else if (halt_stb) nst = 1;
            1: if (core_reset) begin nst = 4; m_cause = 2; end
               else if (host_wr) begin nst = 4; m_cause = ibf_ie ? 1 : 0; end
            2: if (core_reset) begin nst = 3; m_cause = 2; m_cnt = int'(settle_len); end
               else if (m_pend) begin nst = 3; m_cause = ibf_ie ? 1 : 0; m_cnt = int'(settle_len); end
            3: begin
                if (core_reset) m_cause = 2;
                if (m_cnt == 0 && osc_ok) nst = 4;
                else if (m_cnt > 0) m_cnt--;
            end
            default: nst = 0;
        endcase
        m_st = nst;
        m_pend = npend;
    endtask

    task automatic compare();
        logic [5:0] act, exp;
        act = {core_clk_en, osc_en, tmr_clk_en, resume_irq, resume_next, resume_zero};
        exp = {(m_st == 0 || m_st == 4), (m_st != 2), (m_st == 0 || m_st == 1 || m_st == 4),
               (m_st == 4 && m_cause == 1), (m_st == 4 && m_cause == 0),
               (m_st == 4 && m_cause == 2)};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual %b expected %b", tag, cycles, act, exp);
        end
    endtask

    task automatic cyc(input bit h, input bit s, input bit r, input bit w);
        halt_stb = h; stop_stb = s; core_reset = r; host_wr = w;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        halt_stb = 0; stop_stb = 0; core_reset = 0; host_wr = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d actual hung expected done", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        idle(3);                      // R1 held in reset
        rst_n = 1'b1;
        tag = "R1"; idle(2);

        tag = "R2"; cyc(1, 0, 0, 0); idle(2);
        tag = "R10"; cyc(1, 1, 0, 0); idle(1);           // halt/stop ignored in SOFT
        tag = "R4"; ibf_ie = 0; cyc(0, 0, 0, 1); idle(2); // resume_next
        tag = "R10"; cyc(0, 0, 0, 1); idle(1);           // write ignored in RUN
        tag = "R4"; cyc(1, 0, 0, 0); ibf_ie = 1; cyc(0, 0, 0, 1); idle(2); // resume_irq

        tag = "R3"; cyc(1, 1, 0, 0); idle(3);            // stop beats halt
        tag = "R10"; cyc(1, 0, 0, 0); cyc(0, 1, 0, 0); idle(1);
        tag = "R6"; ibf_ie = 0; cyc(0, 0, 0, 1);
        tag = "R7"; idle(3);
        tag = "R10"; cyc(0, 0, 0, 1);                    // write ignored in SETTLE
        tag = "R7"; idle(4);

        tag = "R7"; settle_len = 8'd0; ibf_ie = 1;
        cyc(0, 1, 0, 0); idle(2); osc_ok = 0;
        cyc(0, 0, 0, 1); idle(4); osc_ok = 1; idle(3);

        tag = "R7"; settle_len = 8'd5;
        cyc(0, 1, 0, 0); cyc(0, 0, 0, 1); idle(9);

        tag = "R8"; settle_len = 8'd3;
        cyc(0, 1, 0, 0); idle(1); cyc(0, 0, 1, 1); idle(6); // reset+write in HARD
        cyc(0, 1, 0, 0); cyc(0, 0, 0, 1); idle(1); cyc(0, 0, 1, 0); idle(6); // reset in SETTLE

        tag = "R5"; cyc(1, 1, 1, 0); idle(2);            // reset beats halt/stop in RUN
        cyc(1, 0, 0, 0); cyc(0, 0, 1, 1); idle(2);       // reset beats write in SOFT
        tag = "R9"; cyc(1, 0, 0, 0); ibf_ie = 0; cyc(0, 0, 0, 1); idle(3);

        tag = "R1"; rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule